// File: doc/BRIEF.md
# Startup Reset and Boot Sequencer

This block brings a processor core out of reset in an orderly way. A reset can arrive in two forms. A cold reset comes either from the block's own reset or from the reset pin while the power-on flag is high. A cold reset keeps the core held for a fixed settle count, so the clock generator can lock. A warm reset comes from the reset pin after power-up. It skips that wait, because the clock never stopped.

Reset pin pulses from the running state are glitch-filtered: a low level must persist for a minimum number of cycles before it is taken as a reset. Every reset entry fires single-cycle clear strobes for the stack pointers and for the mode status register, and it masks interrupts. On release the sequencer first waits out any pending bus request. It then either starts the boot loader and waits for its done handshake, or goes straight to instruction fetch. Fetch always begins at the start address, which is zero by default. All inputs are taken as synchronous to `clk_i`.

Top module: `boot_seq_ctrl`

## Requirements
- R1: While `rst_ni` is low: `core_rst_o`=1, `irq_mask_o`=1, `stack_clr_o`=1, `mstat_clr_o`=1, `settle_busy_o`=1, `settle_done_o`=0, `fetch_en_o`=0, `boot_start_o`=0.
- R2: After a cold reset the settle counter runs from zero to SETTLE_CYCLES (default 2000). `settle_busy_o` is high only while it runs. The counter then saturates, and `settle_done_o` stays high. With the reset pin already high, `core_rst_o` is high for exactly SETTLE_CYCLES clock edges after the count starts.
- R3: A warm reset (reset pin low, `por_i`=0) lasting at least MIN_RST_PULSE cycles asserts `core_rst_o` on the MIN_RST_PULSE-th edge at which the pin is sampled low. `core_rst_o` falls on the first edge at which the pin is sampled high. No settle wait occurs.
- R4: A warm reset pulse shorter than MIN_RST_PULSE cycles, seen from the running state, is ignored. `core_rst_o` stays low and `fetch_en_o` stays high.
- R5: `stack_clr_o` and `mstat_clr_o` go high for exactly one cycle, the cycle in which `core_rst_o` first rises on a reset entry.
- R6: `irq_mask_o` is high from reset entry until `fetch_en_o` asserts, and low while fetching.
- R7: If `bus_req_i` is high when reset is released, `boot_start_o` and `fetch_en_o` stay low until `bus_req_i` is sampled low.
- R8: With `boot_en_i`=1, `boot_start_o` is a one-cycle pulse on the edge that leaves reset or bus hold. `fetch_en_o` rises on the edge after `boot_done_i` is first sampled high, and never before.
- R9: With `boot_en_i`=0 and no bus request, `fetch_en_o` rises on the edge at which `core_rst_o` falls. `fetch_addr_o` is START_ADDR (default 0).
- R10: The reset pin low with `por_i`=1 enters reset on the next edge, with no filtering, even from the running state. It restarts the settle count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset (cold) |
| rst_pin_ni | input | 1 | Active-low reset request pin, synchronous |
| por_i | input | 1 | Power-up in progress; makes a pin reset cold |
| boot_en_i | input | 1 | Boot-enable strap |
| bus_req_i | input | 1 | External bus request |
| boot_done_i | input | 1 | Boot loader finished |
| core_rst_o | output | 1 | Core held in reset |
| settle_busy_o | output | 1 | Settle counter running |
| settle_done_o | output | 1 | Settle counter saturated |
| stack_clr_o | output | 1 | Stack pointer clear strobe |
| mstat_clr_o | output | 1 | Mode status clear strobe |
| irq_mask_o | output | 1 | Global interrupt mask |
| boot_start_o | output | 1 | Boot loader start pulse |
| fetch_en_o | output | 1 | Instruction fetch enable |
| fetch_addr_o | output | ADDR_W | First fetch address |

## Verification
The hardest case to reach is a cold reset that lands while the core is already running. It must restart the full settle count, where a warm pulse of the same pin would skip it. The stimulus gets there by first completing a normal start. It then runs warm glitch and warm reset cases. Finally it lowers the pin with `por_i` high from the fetching state and counts the reset cycles against SETTLE_CYCLES. The bus-hold case stacks a pending request on top of an enabled boot. This shows that neither the boot pulse nor the fetch escapes before the request drops.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [1:0] {
    ST_RST  = 2'd0,
    ST_HOLD = 2'd1,
    ST_BOOT = 2'd2,
    ST_RUN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/settle_counter.sv
module settle_counter #(
  parameter int SETTLE_CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (arm_i)          cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign busy_o = (cnt_q != LIMIT);
  assign done_o = (cnt_q == LIMIT);

  a_r2_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !arm_i) |=> done_o);
  a_r10_arm_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> busy_o);
endmodule

// File: rtl/pulse_filter.sv
module pulse_filter #(
  parameter int MIN_RST_PULSE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pin_ni,
  output logic fire_o
);
  localparam int CNT_W = $clog2(MIN_RST_PULSE + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_RST_PULSE - 1);

  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             run_q <= '0;
    else if (!en_i || pin_ni) run_q <= '0;
    else if (run_q != LAST)  run_q <= run_q + 1'b1;
  end

  // fires on the MIN_RST_PULSE-th consecutive low sample
  assign fire_o = en_i && !pin_ni && (run_q == LAST);

  a_r4_fire_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> !pin_ni);
endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 2000,
  parameter int MIN_RST_PULSE = 4,
  parameter int ADDR_W        = 14,
  parameter int START_ADDR    = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_pin_ni,
  input  logic              por_i,
  input  logic              boot_en_i,
  input  logic              bus_req_i,
  input  logic              boot_done_i,
  output logic              core_rst_o,
  output logic              settle_busy_o,
  output logic              settle_done_o,
  output logic              stack_clr_o,
  output logic              mstat_clr_o,
  output logic              irq_mask_o,
  output logic              boot_start_o,
  output logic              fetch_en_o,
  output logic [ADDR_W-1:0] fetch_addr_o
);
  localparam logic [ADDR_W-1:0] START_VEC = ADDR_W'(START_ADDR);

  seq_state_e state_q, state_d;
  logic cold_q, cold_d;
  logic clr_q, boot_start_q;
  logic arm, warm_fire, cold_req, settle_done;

  assign cold_req = !rst_pin_ni && por_i;

  settle_counter #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm),
    .busy_o (settle_busy_o),
    .done_o (settle_done)
  );

  pulse_filter #(.MIN_RST_PULSE(MIN_RST_PULSE)) u_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q != ST_RST),
    .pin_ni (rst_pin_ni),
    .fire_o (warm_fire)
  );

  always_comb begin
    state_d = state_q;
    cold_d  = cold_q;
    arm     = 1'b0;
    if (state_q == ST_RST) begin
      if (cold_req && !cold_q) begin
        // warm reset upgraded to cold: start settling now
        arm    = 1'b1;
        cold_d = 1'b1;
      end else if (rst_pin_ni && (!cold_q || settle_done)) begin
        if (bus_req_i)      state_d = ST_HOLD;
        else if (boot_en_i) state_d = ST_BOOT;
        else                state_d = ST_RUN;
      end
    end else if (cold_req) begin
      state_d = ST_RST;
      arm     = 1'b1;
      cold_d  = 1'b1;
    end else if (warm_fire) begin
      state_d = ST_RST;
      cold_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_HOLD: if (!bus_req_i) state_d = boot_en_i ? ST_BOOT : ST_RUN;
        ST_BOOT: if (boot_done_i) state_d = ST_RUN;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_RST;
      cold_q       <= 1'b1;
      clr_q        <= 1'b1;
      boot_start_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      cold_q       <= cold_d;
      clr_q        <= (state_q != ST_RST) && (state_d == ST_RST);
      boot_start_q <= (state_q != ST_BOOT) && (state_d == ST_BOOT);
    end
  end

  assign core_rst_o    = (state_q == ST_RST);
  assign settle_done_o = settle_done;
  assign stack_clr_o   = clr_q;
  assign mstat_clr_o   = clr_q;
  assign irq_mask_o    = (state_q != ST_RUN);
  assign boot_start_o  = boot_start_q;
  assign fetch_en_o    = (state_q == ST_RUN);
  assign fetch_addr_o  = START_VEC;

  a_r2_busy_holds_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settle_busy_o |-> core_rst_o);
  a_r5_clear_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_o) |-> (stack_clr_o && mstat_clr_o));
  a_r5_clear_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_clr_o |=> !stack_clr_o);
  a_r6_mask_until_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_en_o |-> irq_mask_o);
  a_r7_bus_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(core_rst_o) && $past(bus_req_i)) |-> (!fetch_en_o && !boot_start_o));
  a_r8_boot_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_start_o |=> !boot_start_o);
  a_r8_fetch_after_boot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BOOT && !boot_done_i) |=> !fetch_en_o);
  a_r9_fetch_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_en_o |-> (fetch_addr_o == START_VEC));
endmodule

// File: tb/tb_boot_seq_ctrl.sv
module tb_boot_seq_ctrl;
  localparam int SETTLE = 2000;
  localparam int MINP   = 4;
  localparam int AW     = 14;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, rst_pin_ni = 1'b1, por_i = 1'b0;
  logic boot_en_i = 1'b0, bus_req_i = 1'b0, boot_done_i = 1'b0;
  logic core_rst_o, settle_busy_o, settle_done_o, stack_clr_o, mstat_clr_o;
  logic irq_mask_o, boot_start_o, fetch_en_o;
  logic [AW-1:0] fetch_addr_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  boot_seq_ctrl #(.SETTLE_CYCLES(SETTLE), .MIN_RST_PULSE(MINP), .ADDR_W(AW), .START_ADDR(0)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .rst_pin_ni(rst_pin_ni), .por_i(por_i),
    .boot_en_i(boot_en_i), .bus_req_i(bus_req_i), .boot_done_i(boot_done_i),
    .core_rst_o(core_rst_o), .settle_busy_o(settle_busy_o), .settle_done_o(settle_done_o),
    .stack_clr_o(stack_clr_o), .mstat_clr_o(mstat_clr_o), .irq_mask_o(irq_mask_o),
    .boot_start_o(boot_start_o), .fetch_en_o(fetch_en_o), .fetch_addr_o(fetch_addr_o));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R1 core_rst", core_rst_o, 1);
    chk("R1 irq_mask", irq_mask_o, 1);
    chk("R1 stack_clr", stack_clr_o, 1);
    chk("R1 mstat_clr", mstat_clr_o, 1);
    chk("R1 busy", settle_busy_o, 1);
    chk("R1 done", settle_done_o, 0);
    chk("R1 fetch_en", fetch_en_o, 0);
    chk("R1 boot_start", boot_start_o, 0);
  endtask

  // counts core_rst samples after each edge until it drops
  task automatic count_hold(output int n);
    n = 0;
    for (int i = 0; i < SETTLE + 50; i++) begin
      tick();
      if (!core_rst_o) break;
      n++;
    end
  endtask

  task automatic t_cold_start();
    int n;
    rst_ni = 1'b1;
    tick();
    chk("R2 busy while settling", settle_busy_o, 1);
    chk("R5 strobe one cycle", stack_clr_o, 0);
    count_hold(n);
    chk("R2 cold hold length", n + 1, SETTLE);
    chk("R2 done sticky", settle_done_o, 1);
    chk("R2 busy cleared", settle_busy_o, 0);
    chk("R9 fetch on release", fetch_en_o, 1);
    chk("R9 fetch addr", int'(fetch_addr_o), 0);
    chk("R6 mask cleared", irq_mask_o, 0);
  endtask

  task automatic t_glitch();
    rst_pin_ni = 1'b0;
    for (int i = 0; i < MINP - 1; i++) begin
      tick();
      chk("R4 glitch no reset", core_rst_o, 0);
    end
    rst_pin_ni = 1'b1;
    tick();
    chk("R4 still fetching", fetch_en_o, 1);
    chk("R4 no reset after", core_rst_o, 0);
  endtask

  task automatic t_warm();
    rst_pin_ni = 1'b0;
    for (int i = 0; i < MINP - 1; i++) tick();
    chk("R3 not yet", core_rst_o, 0);
    tick();
    chk("R3 warm entry", core_rst_o, 1);
    chk("R5 stack strobe", stack_clr_o, 1);
    chk("R5 mstat strobe", mstat_clr_o, 1);
    chk("R6 mask set", irq_mask_o, 1);
    chk("R3 no settle busy", settle_busy_o, 0);
    for (int i = 0; i < 3; i++) tick();
    chk("R5 strobe dropped", mstat_clr_o, 0);
    chk("R3 held while low", core_rst_o, 1);
    rst_pin_ni = 1'b1;
    tick();
    chk("R3 warm release", core_rst_o, 0);
    chk("R9 fetch after warm", fetch_en_o, 1);
  endtask

  task automatic t_bus_boot();
    boot_en_i = 1'b1;
    bus_req_i = 1'b1;
    rst_pin_ni = 1'b0;
    for (int i = 0; i < MINP; i++) tick();
    chk("R3 entry for hold", core_rst_o, 1);
    rst_pin_ni = 1'b1;
    tick();
    chk("R7 core released", core_rst_o, 0);
    for (int i = 0; i < 3; i++) begin
      chk("R7 no boot start", boot_start_o, 0);
      chk("R7 no fetch", fetch_en_o, 0);
      tick();
    end
    bus_req_i = 1'b0;
    tick();
    chk("R8 boot start pulse", boot_start_o, 1);
    tick();
    chk("R8 pulse single", boot_start_o, 0);
    for (int i = 0; i < 3; i++) begin
      chk("R8 fetch waits boot", fetch_en_o, 0);
      chk("R6 mask during boot", irq_mask_o, 1);
      tick();
    end
    boot_done_i = 1'b1;
    tick();
    boot_done_i = 1'b0;
    chk("R8 fetch after done", fetch_en_o, 1);
    chk("R8 fetch addr", int'(fetch_addr_o), 0);
    boot_en_i = 1'b0;
  endtask

  task automatic t_cold_from_run();
    int n;
    por_i = 1'b1;
    rst_pin_ni = 1'b0;
    tick();
    chk("R10 immediate entry", core_rst_o, 1);
    chk("R10 busy restarted", settle_busy_o, 1);
    chk("R10 done cleared", settle_done_o, 0);
    chk("R5 strobe on cold", stack_clr_o, 1);
    por_i = 1'b0;
    rst_pin_ni = 1'b1;
    count_hold(n);
    chk("R10 full settle", n, SETTLE);
    chk("R10 fetch resumes", fetch_en_o, 1);
    chk("R2 done again", settle_done_o, 1);
  endtask

  initial begin
    #(64'd200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset_state();
    t_cold_start();
    t_glitch();
    t_warm();
    t_bus_boot();
    t_cold_from_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule